// File: doc/BRIEF.md
# Jitter-Tolerant Sample-Frame Timing Generator

This block derives the once-per-sample frame timing of an oversampling audio path from the local system clock, not from the incoming word clock. A frame counter runs freely from the system clock. Each frame is 192 or 256 counting steps long. In the two high-ratio settings, one counting step lasts two system clocks. The block also produces a sample-rate square wave and a one-clock frame-start strobe for downstream stages.

The word clock is brought in through a two-flop synchronizer. Only its rising (starting) edge is used. For each such edge, the block works out how far the edge lies from the point where its own frame boundary should be.

In tolerant mode, small errors are ignored. The counter is re-phased only when the error goes beyond three eighths of a frame, or on the first edge after reset. In forced mode, every starting edge restarts the frame. Because of this, a jittery word clock does not disturb the output timing unless it drifts far.

Top module: `fs_timing_gen`

## Requirements
- R1: `ratio_sel` picks the frame length in system clocks: 0 gives 192, 1 gives 256, 2 gives 384 and 3 gives 512. With no word-clock edges, `frame_start` pulses once per frame length.
- R2: For `ratio_sel` 2 and 3, `frame_phase` advances once every two system clocks, so a frame holds 192 or 256 phase steps. For 0 and 1 it advances on every clock.
- R3: `frame_start` is high for exactly one clock, in the first clock in which `frame_phase` is 0.
- R4: `fs_clk` is high while `frame_phase` is below half the frame's step count and low otherwise. It is therefore high for half of each frame.
- R5: A rising edge on `wclk_in`, applied between clock edges, acts at the third following rising clock edge. When that edge re-phases the frame, `frame_phase` reads 0 and `frame_start` is high right after that clock edge.
- R6: In tolerant mode (`jitter_free` = 1), after the first edge since reset, a word-clock edge does not change the frame timing if its error lies within ±(3/8 of the step count). The error is the phase the counter would reach at the acting clock edge, read as a signed offset in which values of half the step count or more count as negative.
- R7: In tolerant mode, a word-clock edge whose error magnitude exceeds 3/8 of the step count re-phases the frame as in R5.
- R8: In forced mode (`jitter_free` = 0), every word-clock rising edge re-phases the frame, whatever its error.
- R9: The first word-clock rising edge after reset re-phases the frame even when its error lies inside the window.
- R10: While `rst_n` is low, `frame_phase` is 0, `frame_start` is 0 and `fs_clk` is 1.
- R11: Falling edges of `wclk_in` have no effect on the frame timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; arms alignment to the next word-clock edge |
| wclk_in | input | 1 | Word clock, asynchronous to `clk` |
| jitter_free | input | 1 | 1 = tolerant mode with dead band, 0 = forced re-phase on every edge |
| ratio_sel | input | 2 | System-clock-to-sample-rate ratio (R1 encoding) |
| frame_phase | output | 8 | Current step within the frame |
| frame_start | output | 1 | One-clock strobe at the start of each frame |
| fs_clk | output | 1 | Sample-rate square wave |

## Verification
The result of a word-clock rising edge is due three rising clock edges after the edge is applied. This accounts for two synchronizer flops and one counter update. The bench drives every edge at a falling clock edge and samples exactly three falling edges later, both for the re-phase case and for the left-alone case. In the left-alone case, it predicts the phase from the step count and the number of clocks elapsed since the last alignment. Free-running behaviour is measured over one whole frame, starting from an observed `frame_start`. The bench counts the clocks to the next strobe and the clocks with `fs_clk` high.

// File: rtl/fstg_pkg.sv
package fstg_pkg;

  // Frame length in phase steps for a ratio selection.
  function automatic int unsigned frame_len(input logic [1:0] sel,
                                            input int unsigned short_len,
                                            input int unsigned long_len);
    return sel[0] ? long_len : short_len;
  endfunction

  // Dead-band half-width: three eighths of a frame.
  function automatic int window_limit(input int unsigned len);
    return int'((3 * len) / 8);
  endfunction

  // Signed offset of the phase the counter would reach at the acting edge.
  function automatic int phase_error(input int unsigned phase,
                                     input int unsigned len);
    int unsigned nxt;
    nxt = (phase + 1) % len;
    if (nxt >= len / 2) return int'(nxt) - int'(len);
    return int'(nxt);
  endfunction

  function automatic logic out_of_window(input int err, input int lim);
    return (err > lim) || (err < -lim);
  endfunction

endpackage

// File: rtl/fstg_wclk_sync.sv
module fstg_wclk_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wclk_in,
  output logic rise_evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= wclk_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], wclk_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_evt = sync_q[SYNC_STAGES-1] & ~last_q;

  // R5
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);

endmodule

// File: rtl/fstg_tick_gen.sv
module fstg_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic div2,
  input  logic realign,
  output logic tick
);
  logic half_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       half_q <= 1'b0;
    else if (realign) half_q <= 1'b0;
    else              half_q <= ~half_q;
  end

  assign tick = div2 ? half_q : 1'b1;

  // R2
  tick_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div2 |-> tick);

  // R2
  tick_half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div2 && tick) |=> (!tick || !div2));

endmodule

// File: rtl/fstg_frame_counter.sv
module fstg_frame_counter #(
  parameter int PHASE_W = 8,
  parameter int LEN_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               realign,
  input  logic [LEN_W-1:0]   cur_len,
  output logic [PHASE_W-1:0] phase,
  output logic               start_pulse,
  output logic               fs_level
);
  logic wrap_now;

  assign wrap_now = 32'(phase) >= (32'(cur_len) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= '0;
      start_pulse <= 1'b0;
    end else if (realign) begin
      phase       <= '0;
      start_pulse <= 1'b1;
    end else if (tick) begin
      if (wrap_now) begin
        phase       <= '0;
        start_pulse <= 1'b1;
      end else begin
        phase       <= phase + PHASE_W'(1);
        start_pulse <= 1'b0;
      end
    end else begin
      start_pulse <= 1'b0;
    end
  end

  assign fs_level = 32'(phase) < (32'(cur_len) / 32'd2);

  // R3
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (phase == '0));

  // R3
  start_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && !realign) |=> !start_pulse);

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cur_len) |-> (32'(phase) < 32'(cur_len)));

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !realign) |=> $stable(phase));

endmodule

// File: rtl/fstg_phase_judge.sv
module fstg_phase_judge #(
  parameter int PHASE_W = 8,
  parameter int LEN_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_evt,
  input  logic               jitter_free,
  input  logic [PHASE_W-1:0] phase,
  input  logic [LEN_W-1:0]   cur_len,
  output logic               outside,
  output logic               realign
);
  import fstg_pkg::*;

  logic armed_q;
  int   err_now;
  int   lim_now;

  assign err_now = phase_error(32'(phase), 32'(cur_len));
  assign lim_now = window_limit(32'(cur_len));
  assign outside = out_of_window(err_now, lim_now);

  assign realign = rise_evt & (~jitter_free | armed_q | outside);

  always_ff @(posedge clk) begin
    if (!rst_n)       armed_q <= 1'b1;
    else if (realign) armed_q <= 1'b0;
  end

  // R9
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !armed_q);

  // R9
  armed_acts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && armed_q) |-> realign);

endmodule

// File: rtl/fs_timing_gen.sv
module fs_timing_gen #(
  parameter int LEN_SHORT   = 192,
  parameter int LEN_LONG    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wclk_in,
  input  logic                          jitter_free,
  input  logic [1:0]                    ratio_sel,
  output logic [$clog2(LEN_LONG)-1:0]   frame_phase,
  output logic                          frame_start,
  output logic                          fs_clk
);
  import fstg_pkg::*;

  localparam int PHASE_W = $clog2(LEN_LONG);
  localparam int LEN_W   = PHASE_W + 1;

  logic [LEN_W-1:0] cur_len;
  logic             div2;
  logic             rise_evt;
  logic             outside;
  logic             realign;
  logic             tick;

  assign cur_len = LEN_W'(frame_len(ratio_sel, LEN_SHORT, LEN_LONG));
  assign div2    = ratio_sel[1];

  fstg_wclk_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .wclk_in  (wclk_in),
    .rise_evt (rise_evt)
  );

  fstg_phase_judge #(.PHASE_W(PHASE_W), .LEN_W(LEN_W)) u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_evt    (rise_evt),
    .jitter_free (jitter_free),
    .phase       (frame_phase),
    .cur_len     (cur_len),
    .outside     (outside),
    .realign     (realign)
  );

  fstg_tick_gen u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .div2    (div2),
    .realign (realign),
    .tick    (tick)
  );

  fstg_frame_counter #(.PHASE_W(PHASE_W), .LEN_W(LEN_W)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .realign     (realign),
    .cur_len     (cur_len),
    .phase       (frame_phase),
    .start_pulse (frame_start),
    .fs_level    (fs_clk)
  );

  // R8
  forced_rephase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !jitter_free) |-> realign);

  // R7
  outside_rephase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && outside) |-> realign);

  // R5
  rephase_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (frame_phase == '0 && frame_start));

  // R6
  realign_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> rise_evt);

endmodule

// File: tb/test_fs_timing_gen.sv
module test_fs_timing_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wclk_in = 1'b0;
  logic       jitter_free = 1'b1;
  logic [1:0] ratio_sel = 2'd0;
  logic [7:0] frame_phase;
  logic       frame_start;
  logic       fs_clk;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  fs_timing_gen i_fs_timing_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .wclk_in     (wclk_in),
    .jitter_free (jitter_free),
    .ratio_sel   (ratio_sel),
    .frame_phase (frame_phase),
    .frame_start (frame_start),
    .fs_clk      (fs_clk)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int steps_of(input logic [1:0] rs);
    return rs[0] ? 256 : 192;
  endfunction

  function automatic int div_of(input logic [1:0] rs);
    return rs[1] ? 2 : 1;
  endfunction

  task automatic apply_reset(input logic [1:0] rs, input bit jf);
    step(1);
    rst_n = 1'b0; wclk_in = 1'b0; ratio_sel = rs; jitter_free = jf;
    step(3);
    // R10 reset state
    chk(frame_phase == 0, "R10", "phase in reset", frame_phase, 0);
    chk(frame_start == 0, "R10", "strobe in reset", frame_start, 0);
    chk(fs_clk == 1, "R10", "fs_clk in reset", fs_clk, 1);
    rst_n = 1'b1;
  endtask

  // R1 R2 R3 R4: free-running frame over one whole period
  task automatic run_free(input logic [1:0] rs);
    int per, highs, extra, waited;
    per = steps_of(rs) * div_of(rs);
    apply_reset(rs, 1'b1);
    waited = 0;
    step(1);
    while (!frame_start && waited < 1200) begin step(1); waited++; end
    chk(frame_start == 1, "R1", "first strobe seen", frame_start, 1);
    chk(frame_phase == 0, "R3", "phase at strobe", frame_phase, 0);
    highs = 0; extra = 0;
    for (int i = 0; i < per; i++) begin
      if (fs_clk) highs++;
      if (i > 0 && frame_start) extra++;
      step(1);
    end
    chk(frame_start == 1, "R1", "strobe after one period", frame_start, 1);
    chk(extra == 0, "R3", "strobes inside frame", extra, 0);
    chk(highs == per / 2, "R4", "fs_clk high clocks", highs, per / 2);
    if (div_of(rs) == 2) begin
      step(2);
      chk(frame_phase == 1, "R2", "phase two clocks after start", frame_phase, 1);
    end else begin
      step(1);
      chk(frame_phase == 1, "R2", "phase one clock after start", frame_phase, 1);
    end
  endtask

  // R9: first edge after reset realigns even inside the window
  task automatic run_armed();
    apply_reset(2'd0, 1'b1);
    step(200);
    wclk_in = 1'b1;
    step(3);
    chk(frame_phase == 0, "R9", "phase after armed edge", frame_phase, 0);
    chk(frame_start == 1, "R9", "strobe after armed edge", frame_start, 1);
    step(1);
    wclk_in = 1'b0;
  endtask

  // R5 R6 R7 R8 R11: align, then a second edge at a chosen offset
  task automatic run_offset(input logic [1:0] rs, input bit jf, input int off,
                            input string req);
    int len, dv, per, lim, kdet, p, d, err, exp_ph;
    bit moves;
    len = steps_of(rs); dv = div_of(rs); per = len * dv; lim = len * 3 / 8;
    apply_reset(rs, jf);
    step(10);
    wclk_in = 1'b1;
    step(3);
    // R5 latency of the aligning edge
    chk(frame_phase == 0, "R5", "phase three clocks after edge", frame_phase, 0);
    chk(frame_start == 1, "R5", "strobe three clocks after edge", frame_start, 1);
    step(1);
    wclk_in = 1'b0;
    step(4);
    // R11 falling edge ignored
    chk(frame_phase == (5 / dv) % len, "R11", "phase after falling edge",
        frame_phase, (5 / dv) % len);
    step(per + off - 8);
    wclk_in = 1'b1;
    kdet = per + off - 1;
    p = (kdet / dv) % len;
    d = (p + 1) % len;
    err = (d >= len / 2) ? d - len : d;
    moves = !jf || err > lim || err < -lim;
    exp_ph = moves ? 0 : ((kdet + 1) / dv) % len;
    step(3);
    chk(frame_phase == exp_ph, req, "phase after offset edge", frame_phase, exp_ph);
    chk(frame_start == moves, req, "strobe after offset edge", frame_start, moves);
    step(1);
    wclk_in = 1'b0;
  endtask

  initial begin
    #(5ns * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    run_free(2'd0);
    run_free(2'd1);
    run_free(2'd2);
    run_free(2'd3);
    run_armed();
    run_offset(2'd0, 1'b1,  40, "R6");
    run_offset(2'd0, 1'b1, -40, "R6");
    run_offset(2'd0, 1'b1,  72, "R6");
    run_offset(2'd0, 1'b1, -72, "R6");
    run_offset(2'd0, 1'b1,  73, "R7");
    run_offset(2'd0, 1'b1, -73, "R7");
    run_offset(2'd1, 1'b1,  96, "R6");
    run_offset(2'd1, 1'b1,  97, "R7");
    run_offset(2'd2, 1'b1, 100, "R6");
    run_offset(2'd2, 1'b1, 160, "R7");
    run_offset(2'd3, 1'b0,   6, "R8");
    run_offset(2'd0, 1'b0,  20, "R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule